// File: doc/BRIEF.md
# Per-CPU Interrupt Acknowledge Interface

This block sits between an interrupt distributor and one processor core. Each cycle the distributor presents its best pending candidate: a valid flag, an interrupt ID, a priority and, for software-generated interrupts, the number of the CPU that raised it. The interface filters that candidate against its own enable bit, its priority threshold and its record of interrupts already in service. It raises an interrupt request towards the core when the candidate survives the filter.

Software services interrupts over a 32-bit register bus. A read of the acknowledge register returns the ID of the signalled interrupt and moves it into the active state. The `take_o` pulse tells the distributor to drop that interrupt's pending state. When nothing is signalled, the read returns the spurious ID 1023, so a service loop can stop. A write of the ID to the end-of-interrupt register retires the active interrupt, and `done_o` reports this to the distributor. The active record is private to this interface, so each CPU keeps its own copy for its banked IDs 0 to 31.

Top module: `iack_cpuif`

## Requirements
- R1: After reset the enable bit is 0, the priority threshold is 0, no ID is active, `irq_o` is low, and a read at the acknowledge offset returns 1023.
- R2: Bit 0 of the control register at byte offset 0x00 enables signalling. A read of that register returns the enable in bit 0 and zeros in all other bits. Other written bits are dropped.
- R3: The threshold register at offset 0x04 holds the 8 low bits written to it, for example 0xF0, and reads them back zero-extended. A candidate is signalled only if its priority is numerically below the threshold.
- R4: `irq_o` is high in exactly the cycles where all of these hold: the interface is enabled, `fwd_valid` is high, `fwd_id` is below NUM_IDS (default 64), that ID is not active, and the priority passes the threshold.
- R5: A read at offset 0x0C while `irq_o` is high returns the ID in bits 9:0 and zeros in bits 31:13. Bits 12:10 hold `fwd_src` for IDs 0 to 15 and are zero for other IDs. In the same cycle `take_o` pulses, with `take_id_o` equal to the ID.
- R6: A read at offset 0x0C while `irq_o` is low returns 1023. It raises no `take_o` and changes no state.
- R7: An acknowledged ID becomes active from the next cycle. While it is active, a candidate carrying that ID is not signalled and is not returned, even if the distributor keeps presenting it.
- R8: A write to offset 0x10 names an ID in bits 9:0 and ignores bits 31:10. If that ID is active, the write clears it and pulses `done_o` in the same cycle, with `done_id_o` equal to the ID.
- R9: An end-of-interrupt write that names an ID that is not active, or an ID at or above NUM_IDS, has no effect. It gives no `done_o` and changes no active state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| fwd_valid | input | 1 | Distributor presents a candidate |
| fwd_id | input | 10 | Candidate interrupt ID |
| fwd_prio | input | 8 | Candidate priority, lower value is more urgent |
| fwd_src | input | 3 | Requesting CPU for software-generated IDs |
| irq_o | output | 1 | Interrupt request to the core |
| take_o | output | 1 | Acknowledge taken, distributor clears pending |
| take_id_o | output | 10 | ID that was acknowledged |
| done_o | output | 1 | End-of-interrupt accepted |
| done_id_o | output | 10 | ID that was retired |

## Verification
Two kinds of internal fault show up at the ports. A stale or lost active bit shows up at once: `irq_o` stays asserted for an ID that was just acknowledged, or an end-of-interrupt write fails to raise `done_o`, both within the cycle after the access. A corrupted threshold or enable shows up on the next candidate, as `irq_o` at the wrong priority boundary or as a wrong register read-back. A fault in the acknowledge word shows up in the same read cycle: a missing spurious value or misplaced source-CPU bits.

// File: rtl/iack_pkg.sv
package iack_pkg;
    localparam int ID_W = 10;
    localparam logic [ID_W-1:0] SPURIOUS_ID = 10'd1023;
    localparam logic [ID_W-1:0] SGI_LIMIT = 10'd16;
    localparam logic [7:0] OFS_CTRL = 8'h00;
    localparam logic [7:0] OFS_MASK = 8'h04;
    localparam logic [7:0] OFS_ACK  = 8'h0C;
    localparam logic [7:0] OFS_EOI  = 8'h10;
endpackage

// File: rtl/iack_gate.sv
module iack_gate
    import iack_pkg::*;
#(
    parameter int NUM_IDS = 64,
    parameter int PRIO_W  = 8
) (
    input  logic                en_i,
    input  logic [PRIO_W-1:0]   mask_i,
    input  logic [NUM_IDS-1:0]  active_i,
    input  logic                fwd_valid_i,
    input  logic [ID_W-1:0]     fwd_id_i,
    input  logic [PRIO_W-1:0]   fwd_prio_i,
    input  logic [2:0]          fwd_src_i,
    output logic                pass_o,
    output logic [31:0]         ack_word_o
);
    localparam int IXW = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1;
    localparam logic [ID_W-1:0] ID_LIMIT = ID_W'(NUM_IDS);

    logic in_range;
    logic is_active;
    logic [2:0] src_field;

    always_comb begin
        in_range   = fwd_id_i < ID_LIMIT;
        is_active  = in_range ? active_i[fwd_id_i[IXW-1:0]] : 1'b0;
        pass_o     = en_i && fwd_valid_i && in_range && !is_active
                     && (fwd_prio_i < mask_i);
        src_field  = (fwd_id_i < SGI_LIMIT) ? fwd_src_i : 3'b000;
        ack_word_o = {22'b0, SPURIOUS_ID};
        if (pass_o) begin
            ack_word_o = {19'b0, src_field, fwd_id_i};
        end
    end
endmodule

// File: rtl/iack_active.sv
module iack_active
    import iack_pkg::*;
#(
    parameter int NUM_IDS = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_i,
    input  logic [ID_W-1:0]     set_id_i,
    input  logic                clr_req_i,
    input  logic [ID_W-1:0]     clr_id_i,
    output logic                clr_hit_o,
    output logic [NUM_IDS-1:0]  active_o
);
    localparam int IXW = (NUM_IDS > 1) ? $clog2(NUM_IDS) : 1;
    localparam logic [ID_W-1:0] ID_LIMIT = ID_W'(NUM_IDS);

    typedef struct packed {
        logic [NUM_IDS-1:0] act;
    } act_t;

    act_t s_d, s_q;
    logic clr_in;

    always_comb begin
        s_d       = s_q;
        clr_in    = clr_req_i && (clr_id_i < ID_LIMIT);
        clr_hit_o = clr_in && s_q.act[clr_id_i[IXW-1:0]];
        if (clr_hit_o) begin
            s_d.act[clr_id_i[IXW-1:0]] = 1'b0;
        end
        if (set_i) begin
            s_d.act[set_id_i[IXW-1:0]] = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign active_o = s_q.act;
endmodule

// File: rtl/iack_cpuif.sv
module iack_cpuif
    import iack_pkg::*;
#(
    parameter int NUM_IDS = 64,
    parameter int PRIO_W  = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        fwd_valid,
    input  logic [9:0]  fwd_id,
    input  logic [7:0]  fwd_prio,
    input  logic [2:0]  fwd_src,
    output logic        irq_o,
    output logic        take_o,
    output logic [9:0]  take_id_o,
    output logic        done_o,
    output logic [9:0]  done_id_o
);
    typedef struct packed {
        logic              en;
        logic [PRIO_W-1:0] mask;
    } ctl_t;

    ctl_t c_d, c_q;
    logic en_q;
    logic [PRIO_W-1:0] mask_q;
    logic rd, wr, ack_rd, eoi_wr;
    logic pass;
    logic [31:0] ack_word;
    logic [NUM_IDS-1:0] active;
    logic clr_hit;

    assign en_q   = c_q.en;
    assign mask_q = c_q.mask;

    always_comb begin
        rd     = bus_sel && !bus_wr;
        wr     = bus_sel && bus_wr;
        ack_rd = rd && (bus_addr == OFS_ACK);
        eoi_wr = wr && (bus_addr == OFS_EOI);
        c_d    = c_q;
        if (wr && bus_addr == OFS_CTRL) begin
            c_d.en = bus_wdata[0];
        end
        if (wr && bus_addr == OFS_MASK) begin
            c_d.mask = bus_wdata[PRIO_W-1:0];
        end
        bus_rdata = '0;
        if (rd) begin
            case (bus_addr)
                OFS_CTRL: bus_rdata = {31'b0, c_q.en};
                OFS_MASK: bus_rdata = 32'(c_q.mask);
                OFS_ACK:  bus_rdata = ack_word;
                default:  bus_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    iack_gate #(.NUM_IDS(NUM_IDS), .PRIO_W(PRIO_W)) u_gate (
        .en_i        (c_q.en),
        .mask_i      (c_q.mask),
        .active_i    (active),
        .fwd_valid_i (fwd_valid),
        .fwd_id_i    (fwd_id),
        .fwd_prio_i  (fwd_prio[PRIO_W-1:0]),
        .fwd_src_i   (fwd_src),
        .pass_o      (pass),
        .ack_word_o  (ack_word)
    );

    iack_active #(.NUM_IDS(NUM_IDS)) u_active (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_i     (take_o),
        .set_id_i  (fwd_id),
        .clr_req_i (eoi_wr),
        .clr_id_i  (bus_wdata[ID_W-1:0]),
        .clr_hit_o (clr_hit),
        .active_o  (active)
    );

    assign irq_o     = pass;
    assign take_o    = ack_rd && pass;
    assign take_id_o = fwd_id;
    assign done_o    = clr_hit;
    assign done_id_o = bus_wdata[ID_W-1:0];
endmodule

// File: rtl/iack_cpuif_chk.sv
module iack_cpuif_chk
    import iack_pkg::*;
#(
    parameter int PRIO_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [7:0]        bus_addr,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic              fwd_valid,
    input logic [9:0]        fwd_id,
    input logic [7:0]        fwd_prio,
    input logic              irq_o,
    input logic              take_o,
    input logic [9:0]        take_id_o,
    input logic              done_o,
    input logic [9:0]        done_id_o,
    input logic              en_q,
    input logic [PRIO_W-1:0] mask_q
);
    // R4
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (en_q && fwd_valid && (fwd_prio[PRIO_W-1:0] < mask_q)));

    // R5
    take_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> (irq_o && bus_rdata[9:0] == take_id_o && bus_rdata[31:13] == 19'b0));

    // R6
    idle_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == OFS_ACK && !irq_o)
            |-> (bus_rdata == 32'd1023 && !take_o));

    // R7
    active_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |=> !(irq_o && fwd_id == $past(take_id_o)));

    // R8
    done_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (bus_sel && bus_wr && bus_addr == OFS_EOI
                    && bus_wdata[9:0] == done_id_o));
endmodule

bind iack_cpuif iack_cpuif_chk #(.PRIO_W(PRIO_W)) u_chk (.*);

// File: tb/test_iack_cpuif.sv
`timescale 1ns/1ps
module test_iack_cpuif;
    localparam int N = 64;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        bus_sel, bus_wr;
    logic [7:0]  bus_addr;
    logic [31:0] bus_wdata, bus_rdata;
    logic        fwd_valid;
    logic [9:0]  fwd_id;
    logic [7:0]  fwd_prio;
    logic [2:0]  fwd_src;
    logic        irq_o, take_o, done_o;
    logic [9:0]  take_id_o, done_id_o;

    always #2.5 clk = ~clk;

    iack_cpuif i_iack_cpuif (.*);

    int checks = 0;
    int fails  = 0;
    bit finished = 0;
    bit m_en;
    logic [7:0] m_mask;
    bit m_act [N];

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic bit m_pass();
        bit act_bit;
        act_bit = (fwd_id < N) ? m_act[fwd_id] : 1'b0;
        return m_en && fwd_valid && (fwd_id < N) && !act_bit && (fwd_prio < m_mask);
    endfunction

    function automatic logic [31:0] m_ack();
        if (!m_pass()) return 32'd1023;
        return {19'b0, (fwd_id < 16) ? fwd_src : 3'b0, fwd_id};
    endfunction

    task automatic fwd(bit v, int id, int prio, int src);
        fwd_valid = v;
        fwd_id    = 10'(id);
        fwd_prio  = 8'(prio);
        fwd_src   = 3'(src);
    endtask

    // one bus cycle: drive after negedge, check before posedge, update model
    task automatic cyc(bit sel, bit wr, logic [7:0] addr, logic [31:0] wd);
        logic [31:0] exp_rd;
        bit exp_take, exp_done;
        int eid;
        bus_sel = sel; bus_wr = wr; bus_addr = addr; bus_wdata = wd;
        #1;
        chk("R4 irq", {31'b0, irq_o}, {31'b0, m_pass()});
        exp_take = sel && !wr && addr == 8'h0C && m_pass();
        chk("R5 take", {31'b0, take_o}, {31'b0, exp_take});
        if (exp_take) chk("R5 take_id", {22'b0, take_id_o}, {22'b0, fwd_id});
        if (sel && !wr) begin
            case (addr)
                8'h00:   exp_rd = {31'b0, m_en};
                8'h04:   exp_rd = {24'b0, m_mask};
                8'h0C:   exp_rd = m_ack();
                default: exp_rd = 32'b0;
            endcase
            chk((addr == 8'h0C) ? "R6 ack read" : "R2 reg read", bus_rdata, exp_rd);
        end
        eid = int'(wd[9:0]);
        exp_done = sel && wr && addr == 8'h10 && eid < N && m_act[eid];
        chk("R9 done", {31'b0, done_o}, {31'b0, exp_done});
        if (exp_done) chk("R8 done_id", {22'b0, done_id_o}, {22'b0, wd[9:0]});
        @(posedge clk);
        if (sel && wr && addr == 8'h00) m_en = wd[0];
        if (sel && wr && addr == 8'h04) m_mask = wd[7:0];
        if (exp_take) m_act[fwd_id] = 1'b1;
        if (exp_done) m_act[eid] = 1'b0;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic idle();
        cyc(1'b0, 1'b0, 8'h00, 32'h0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0;
        bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
        fwd(1, 40, 0, 0);
        m_en = 0; m_mask = 8'h00;
        foreach (m_act[i]) m_act[i] = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        #0.5;
        chk("R1 irq after reset", {31'b0, irq_o}, 32'd0);
        @(negedge clk);
        cyc(1, 0, 8'h0C, 0);
        cyc(1, 0, 8'h00, 0);
        cyc(1, 0, 8'h04, 0);
        // R2: enable with all bits set, only bit 0 kept
        cyc(1, 1, 8'h00, 32'hFFFF_FFFF);
        cyc(1, 0, 8'h00, 0);
        // R2 irq still low since threshold 0 blocks all (R3)
        idle();
        // R3: threshold 0xF0
        cyc(1, 1, 8'h04, 32'hFFFF_FFF0);
        cyc(1, 0, 8'h04, 0);
        fwd(1, 40, 8'hEF, 0); idle();
        chk("R3 prio EF passes", {31'b0, irq_o}, 32'd1);
        fwd(1, 40, 8'hF0, 0); idle();
        chk("R3 prio F0 blocked", {31'b0, irq_o}, 32'd0);
        // R2 disable blocks
        fwd(1, 40, 8'h10, 0);
        cyc(1, 1, 8'h00, 0);
        idle();
        chk("R2 disabled irq", {31'b0, irq_o}, 32'd0);
        cyc(1, 1, 8'h00, 1);
        // R5 software interrupt with source cpu
        fwd(1, 5, 8'h10, 6);
        #1 chk("R5 sgi ack word", bus_rdata, 32'h0);
        bus_sel = 1; bus_wr = 0; bus_addr = 8'h0C;
        #0.5 chk("R5 sgi ack word", bus_rdata, 32'h0000_1805);
        @(negedge clk); bus_sel = 0;
        m_act[5] = 1'b1;
        // R7 level source still presented
        idle();
        chk("R7 active blocks irq", {31'b0, irq_o}, 32'd0);
        cyc(1, 0, 8'h0C, 0);
        // R8 full acknowledge word written back
        cyc(1, 1, 8'h10, 32'hFFFF_FC05);
        chk("R8 id 5 cleared", {31'b0, m_act[5]}, 32'd0);
        idle();
        chk("R8 irq back", {31'b0, irq_o}, 32'd1);
        // R9 eoi for inactive ids
        cyc(1, 1, 8'h10, 32'd5);
        cyc(1, 1, 8'h10, 32'd40);
        cyc(1, 1, 8'h10, 32'd1023);
        // R5 non-software ID, source bits zero
        fwd(1, 37, 8'h01, 7);
        cyc(1, 0, 8'h0C, 0);
        cyc(1, 1, 8'h10, 32'd37);
        // R4 out-of-range ID
        fwd(1, 70, 8'h01, 0);
        idle();
        chk("R4 out of range", {31'b0, irq_o}, 32'd0);

        // constrained random phase
        void'($urandom(32'd20240611));
        for (int k = 0; k < 4000; k++) begin
            int op;
            fwd(($urandom % 10) < 8, $urandom % 72, $urandom % 256, $urandom % 8);
            op = $urandom % 100;
            if (op < 40)      idle();
            else if (op < 65) cyc(1, 0, 8'h0C, 0);
            else if (op < 85) cyc(1, 1, 8'h10, {$urandom} & 32'hFFFF_FC00 | ($urandom % 66));
            else if (op < 90) cyc(1, 1, 8'h04, 32'h80 | $urandom);
            else if (op < 94) cyc(1, 1, 8'h00, (($urandom % 8) != 0) ? 32'h1 : 32'h0);
            else              cyc(1, 0, (($urandom % 2) != 0) ? 8'h00 : 8'h04, 0);
        end

        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule